// File: doc/BRIEF.md
# USB Bus Suspend Detector

This block watches the two already-synchronized data lines of a full-speed USB device port and reports a bus suspend once the line has sat in the idle (J) state for longer than a programmable window. It raises an interrupt when the suspend interrupt enable is set. When software acknowledges the suspend flag, the block places the transceiver pad into its low-power idle mode.

While the pad is idle, the block watches the lines for a wake-up through a path that needs no clock edge. Any departure from J releases the pad at once, even when the detection clock is stopped. The wake event is then carried through a synchronizer into the clocked domain. There it clears the pad-idle state and produces a single-cycle wake pulse.

Software can stop the idle counter with a clock-disable control. This keeps a second suspend from being reported one window after the acknowledge.

Top module: `usb_susp_det`

## Requirements
- R1: While reset is asserted and after it is released, `susp_flag_o`, `susp_irq_o`, `pad_idle_o` and `wake_pulse_o` are all 0.
- R2: The idle state is J, encoded as `dp_i`=1 and `dm_i`=0. `susp_flag_o` becomes 1 after the rising clock edge that samples J for the (IDLE_CYCLES+1)-th consecutive time. It is 0 after the IDLE_CYCLES-th such edge.
- R3: Any other line state restarts the idle window: K (`dp_i`=0, `dm_i`=1), SE0 (0,0) and SE1 (1,1).
- R4: Counting happens only while `usb_en_i`=1, `clk_en_i`=1 and `clk_gate_i`=0. In any other combination no suspend is reported, and the window restarts from zero.
- R5: `susp_irq_o` is 1 exactly when `susp_flag_o` is 1 and `susp_ie_i` is 1.
- R6: A `susp_clr_i` pulse while the flag is set clears the flag and drives `pad_idle_o` to 1 after that edge. A `susp_clr_i` pulse while the flag is clear has no effect on the flag, on the pad, or on the idle window in progress.
- R7: After an acknowledge, the idle window restarts. With counting still allowed, the flag sets again after another IDLE_CYCLES+1 edges of J.
- R8: While the pad is idle, any non-J line state drives `pad_idle_o` to 0 at once, with no clock edge required, including while the clock is stopped.
- R9: Each wake event yields exactly one `wake_pulse_o` cycle. It is high between the SYNC_STAGES-th and (SYNC_STAGES+1)-th rising edges after the event.
- R10: Non-J line states while the pad is not idle produce no wake pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Detection clock (may be stopped) |
| rst_ni | input | 1 | Asynchronous reset, active low |
| dp_i | input | 1 | Synchronized D+ level |
| dm_i | input | 1 | Synchronized D- level |
| usb_en_i | input | 1 | Controller enable |
| clk_en_i | input | 1 | Controller clocks running |
| clk_gate_i | input | 1 | Software idle-counter clock disable |
| susp_ie_i | input | 1 | Suspend interrupt enable |
| susp_clr_i | input | 1 | Software acknowledge of the suspend flag |
| susp_flag_o | output | 1 | Suspend detected flag |
| susp_irq_o | output | 1 | Suspend interrupt |
| pad_idle_o | output | 1 | Transceiver pad low-power request |
| wake_pulse_o | output | 1 | One-cycle wake-up indication |

## Verification
The bench builds the block with IDLE_CYCLES=20 and SYNC_STAGES=2. The small window lets every idle run length from 1 to IDLE_CYCLES+3 be swept, together with breaks by each non-J state at several positions and all eight enable combinations. With two synchronizer stages, the wake pulse lands on a known edge. The bench also stops its own clock while the pad is idle to confirm that the release needs no clock edge.

// File: rtl/usb_susp_pkg.sv
`timescale 1ns/1ps
package usb_susp_pkg;

  // Line state as {dp, dm}
  typedef enum logic [1:0] {
    LS_SE0 = 2'b00,
    LS_K   = 2'b01,
    LS_J   = 2'b10,
    LS_SE1 = 2'b11
  } line_st_t;

  function automatic logic line_is_idle(input logic dp, input logic dm);
    return line_st_t'({dp, dm}) == LS_J;
  endfunction

endpackage

// File: rtl/usb_susp_sync.sv
`timescale 1ns/1ps
module usb_susp_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);

  logic [STAGES-1:0] stage_q;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stage_q[0] <= 1'b0;
        else         stage_q[0] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stage_q[i] <= 1'b0;
        else         stage_q[i] <= stage_q[i-1];
      end
    end
  end

  assign q_o = stage_q[STAGES-1];

endmodule

// File: rtl/usb_susp_idle_timer.sv
`timescale 1ns/1ps
module usb_susp_idle_timer #(
  parameter int IDLE_CYCLES = 144000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic idle_i,
  input  logic restart_i,
  output logic hit_o
);

  localparam int CW = $clog2(IDLE_CYCLES + 1);
  localparam logic [CW-1:0] LIMIT = CW'(IDLE_CYCLES);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                            cnt_q <= '0;
    else if (!run_i || !idle_i || restart_i) cnt_q <= '0;
    else if (cnt_q != LIMIT)                cnt_q <= cnt_q + 1'b1;
  end

  // Window exceeded: limit reached and this sample is idle too
  assign hit_o = run_i && idle_i && !restart_i && (cnt_q == LIMIT);

endmodule

// File: rtl/usb_susp_wake.sv
`timescale 1ns/1ps
module usb_susp_wake #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pad_idle_i,
  input  logic line_idle_i,
  output logic hold_o,
  output logic pulse_o
);

  logic wake_set;
  logic hold_q;
  logic synced;
  logic synced_last_q;

  // Clockless capture: any line activity during pad idle sets the hold
  assign wake_set = pad_idle_i && !line_idle_i;

  always_ff @(posedge clk_i or negedge rst_ni or posedge wake_set) begin
    if (!rst_ni)                     hold_q <= 1'b0;
    else if (wake_set)               hold_q <= 1'b1;
    else if (synced && !pad_idle_i)  hold_q <= 1'b0;
  end

  usb_susp_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (hold_q),
    .q_o    (synced)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) synced_last_q <= 1'b0;
    else         synced_last_q <= synced;
  end

  assign hold_o  = hold_q;
  assign pulse_o = synced && !synced_last_q;

endmodule

// File: rtl/usb_susp_det.sv
`timescale 1ns/1ps
module usb_susp_det
  import usb_susp_pkg::*;
#(
  parameter int IDLE_CYCLES = 144000,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic dp_i,
  input  logic dm_i,
  input  logic usb_en_i,
  input  logic clk_en_i,
  input  logic clk_gate_i,
  input  logic susp_ie_i,
  input  logic susp_clr_i,
  output logic susp_flag_o,
  output logic susp_irq_o,
  output logic pad_idle_o,
  output logic wake_pulse_o
);

  logic line_idle;
  logic run;
  logic ack;
  logic hit;
  logic flag_q;
  logic pad_q;
  logic wake_hold;
  logic wake_rel;

  assign line_idle = line_is_idle(dp_i, dm_i);
  assign run       = usb_en_i && clk_en_i && !clk_gate_i;
  assign ack       = susp_clr_i && flag_q;

  usb_susp_idle_timer #(.IDLE_CYCLES(IDLE_CYCLES)) u_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_i     (run),
    .idle_i    (line_idle),
    .restart_i (ack),
    .hit_o     (hit)
  );

  usb_susp_wake #(.SYNC_STAGES(SYNC_STAGES)) u_wake (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .pad_idle_i  (pad_q),
    .line_idle_i (line_idle),
    .hold_o      (wake_hold),
    .pulse_o     (wake_rel)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  flag_q <= 1'b0;
    else if (ack) flag_q <= 1'b0;
    else if (hit) flag_q <= 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       pad_q <= 1'b0;
    else if (wake_rel) pad_q <= 1'b0;
    else if (ack)      pad_q <= 1'b1;
  end

  assign susp_flag_o  = flag_q;
  assign susp_irq_o   = flag_q && susp_ie_i;
  assign pad_idle_o   = pad_q && !wake_hold;
  assign wake_pulse_o = wake_rel;

endmodule

// File: rtl/usb_susp_det_chk.sv
`timescale 1ns/1ps
module usb_susp_det_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic dp_i,
  input logic dm_i,
  input logic usb_en_i,
  input logic clk_en_i,
  input logic clk_gate_i,
  input logic susp_ie_i,
  input logic susp_clr_i,
  input logic susp_flag_o,
  input logic susp_irq_o,
  input logic pad_idle_o,
  input logic wake_pulse_o
);

  // R2
  flag_rise_on_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(susp_flag_o) |-> $past(dp_i && !dm_i));

  // R4
  flag_rise_when_run_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(susp_flag_o) |-> $past(usb_en_i && clk_en_i && !clk_gate_i));

  // R6
  flag_fall_on_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(susp_flag_o) |-> $past(susp_clr_i));

  // R6
  pad_rise_on_ack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pad_idle_o) |-> $past(susp_flag_o && susp_clr_i));

  // R5
  irq_needs_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    susp_irq_o |-> (susp_flag_o && susp_ie_i));

  // R9
  wake_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_pulse_o |=> !wake_pulse_o);

  // R8
  wake_pad_released_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_pulse_o |-> !pad_idle_o);

endmodule

bind usb_susp_det usb_susp_det_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .dp_i         (dp_i),
  .dm_i         (dm_i),
  .usb_en_i     (usb_en_i),
  .clk_en_i     (clk_en_i),
  .clk_gate_i   (clk_gate_i),
  .susp_ie_i    (susp_ie_i),
  .susp_clr_i   (susp_clr_i),
  .susp_flag_o  (susp_flag_o),
  .susp_irq_o   (susp_irq_o),
  .pad_idle_o   (pad_idle_o),
  .wake_pulse_o (wake_pulse_o)
);

// File: tb/sim_usb_susp_det.sv
`timescale 1ns/1ps
module sim_usb_susp_det;

  localparam int IDLE = 20;

  logic clk = 1'b0;
  logic clk_on = 1'b1;
  logic rst_n = 1'b0;
  logic dp = 1'b0, dm = 1'b1;
  logic en = 1'b1, cen = 1'b1, gate = 1'b0, ie = 1'b0, clr = 1'b0;
  logic flag, irq, pad, wpulse;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always begin
    #2.5;
    if (clk_on) clk = ~clk;
  end

  usb_susp_det #(.IDLE_CYCLES(IDLE), .SYNC_STAGES(2)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .dp_i(dp), .dm_i(dm),
    .usb_en_i(en), .clk_en_i(cen), .clk_gate_i(gate),
    .susp_ie_i(ie), .susp_clr_i(clr),
    .susp_flag_o(flag), .susp_irq_o(irq),
    .pad_idle_o(pad), .wake_pulse_o(wpulse)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic line(input logic p, input logic m);
    dp = p; dm = m;
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    line(1'b0, 1'b1);
    en = 1'b1; cen = 1'b1; gate = 1'b0; ie = 1'b0; clr = 1'b0;
    cyc(2);
    rst_n = 1'b1;
    cyc(1);
  endtask

  task automatic count_pulses(input int n, output int cnt);
    cnt = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (wpulse) cnt++;
    end
  endtask

  task automatic ack();
    clr = 1'b1;
    cyc(1);
    clr = 1'b0;
  endtask

  initial begin
    #500000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int np;
    cyc(1);
    // R1: during reset
    chk("R1 flag in reset", flag, 0);
    chk("R1 pad in reset", pad, 0);
    do_reset();
    chk("R1 flag", flag, 0);
    chk("R1 irq", irq, 0);
    chk("R1 pad", pad, 0);
    chk("R1 pulse", wpulse, 0);

    // R2 / R5: sweep idle run length
    for (int len = 1; len <= IDLE + 3; len++) begin
      do_reset();
      ie = len[0];
      line(1'b1, 1'b0);
      cyc(len);
      chk("R2 flag vs idle length", flag, (len >= IDLE + 1) ? 1 : 0);
      chk("R5 irq", irq, ((len >= IDLE + 1) && len[0]) ? 1 : 0);
    end

    // R3: break by each non-J state at several positions
    for (int s = 0; s < 3; s++) begin
      for (int b = 0; b < 3; b++) begin
        int pos;
        pos = (b == 0) ? 1 : (b == 1) ? IDLE / 2 : IDLE;
        do_reset();
        line(1'b1, 1'b0);
        cyc(pos);
        if (s == 0) line(1'b0, 1'b1);
        else if (s == 1) line(1'b0, 1'b0);
        else line(1'b1, 1'b1);
        cyc(1);
        line(1'b1, 1'b0);
        cyc(IDLE);
        chk("R3 no flag after break", flag, 0);
        cyc(1);
        chk("R3 flag after full window", flag, 1);
      end
    end

    // R4: all enable combinations
    for (int c = 0; c < 8; c++) begin
      do_reset();
      en = c[0]; cen = c[1]; gate = c[2];
      line(1'b1, 1'b0);
      cyc(IDLE + 3);
      chk("R4 flag vs enables", flag, (c == 3) ? 1 : 0);
    end

    // R4: a one-cycle gate restarts the window
    do_reset();
    line(1'b1, 1'b0);
    cyc(IDLE);
    gate = 1'b1;
    cyc(1);
    gate = 1'b0;
    cyc(IDLE);
    chk("R4 window restarted by gate", flag, 0);
    cyc(1);
    chk("R4 flag after restart", flag, 1);

    // R6: clear with flag low has no effect
    do_reset();
    line(1'b1, 1'b0);
    cyc(5);
    ack();
    chk("R6 stray clr flag", flag, 0);
    chk("R6 stray clr pad", pad, 0);
    cyc(IDLE + 1 - 6);
    chk("R6 window kept, flag", flag, 1);

    // R6 / R7 / R8 / R9 with running clock
    do_reset();
    ie = 1'b1;
    line(1'b1, 1'b0);
    cyc(IDLE + 1);
    chk("R2 flag before ack", flag, 1);
    ack();
    chk("R6 flag cleared", flag, 0);
    chk("R6 irq cleared", irq, 0);
    chk("R6 pad idle", pad, 1);
    cyc(IDLE);
    chk("R7 no early redetect", flag, 0);
    cyc(1);
    chk("R7 redetect", flag, 1);
    chk("R7 pad held", pad, 1);
    line(1'b0, 1'b1);
    #1;
    chk("R8 pad released at once", pad, 0);
    @(negedge clk);
    chk("R9 no pulse after one edge", wpulse, 0);
    @(negedge clk);
    chk("R9 pulse after two edges", wpulse, 1);
    count_pulses(6, np);
    chk("R9 single pulse", np, 0);
    line(1'b1, 1'b0);
    cyc(1);
    chk("R8 pad stays released", pad, 0);

    // R10: activity without pad idle
    do_reset();
    for (int i = 0; i < 4; i++) begin
      line(1'b0, 1'b1); cyc(1);
      line(1'b0, 1'b0); cyc(1);
    end
    count_pulses(4, np);
    chk("R10 no pulse", np, 0);

    // R8 / R9 with clock stopped; R4 gate prevents redetect
    do_reset();
    line(1'b1, 1'b0);
    cyc(IDLE + 1);
    gate = 1'b1;
    ack();
    chk("R6 pad idle (gated)", pad, 1);
    cyc(3 * IDLE);
    chk("R4 no redetect while gated", flag, 0);
    clk_on = 1'b0;
    line(1'b0, 1'b0);
    #20;
    chk("R8 release with clock stopped", pad, 0);
    chk("R9 no pulse while stopped", wpulse, 0);
    line(1'b1, 1'b0);
    #20;
    chk("R8 pad still released", pad, 0);
    clk_on = 1'b1;
    count_pulses(6, np);
    chk("R9 one pulse after restart", np, 1);
    chk("R8 pad after restart", pad, 0);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule